// File: doc/BRIEF.md
# PCI Target Transaction Responder

This block is the target side of a simplified 32-bit PCI agent. It watches the shared address/data bus for the start of a transaction, decodes the bus command and address against its own small configuration header, and claims matching cycles with medium-speed device-select timing. Configuration cycles are served entirely inside the block. Memory and I/O cycles are forwarded to a plain local port: write strobes carry the data and per-byte enables straight through, and read data is taken combinationally from the user logic.

The header holds a read-only identity word and a class/revision word. It also holds a command word whose bit 0 enables the I/O window and bit 1 enables the memory window, a fixed status word, one memory base register (dword 4) and one I/O base register (dword 5). Bursts run one data phase per clock with the address stepping by four. A configuration data phase asserts STOP# together with TRDY#, so configuration bursts are disconnected after one word. Every transaction ends with one turnaround cycle before the block returns to idle.

Top module: `pci_tgt_responder`

## Requirements
- R1: DEVSEL# and TRDY# go low together in the second clock after the edge that samples FRAME# first low (medium decode), and stay high in the clock before that.
- R2: Commands 1010 (config read) and 1011 (config write) are claimed only with IDSEL high and AD[1:0]=00 at the address phase; these cycles never strobe the local port.
- R3: Memory commands (0110, 0111, 1100, 1110, 1111) are claimed only when command bit 1 is set and AD[31:MEM_LOG2] equals the memory base. I/O commands (0010, 0011) are claimed only when command bit 0 is set and AD[31:IO_LOG2] equals the I/O base. All other cases produce no DEVSEL#.
- R4: In a claimed memory or I/O write data phase with IRDY# low, lcl_wr is high, and lcl_addr, lcl_wdata and lcl_be=~C/BE# present the phase unchanged. lcl_io is 1 for I/O cycles.
- R5: In a claimed memory or I/O read data phase, lcl_be is 1111 whatever C/BE# carries, ad_oe is high and ad_out equals the full 32-bit lcl_rdata.
- R6: Interrupt-acknowledge (command 0000) is never claimed.
- R7: Config dword 1 reads {16'h0200, command}. Only command bits 0, 1, 2, 6 and 8 are writable, so bit 7 always reads 0. Config writes honour byte enables. Dword 4 reads the memory base with its low MEM_LOG2 bits zero, and dword 5 reads the I/O base with bit 0 set.
- R8: While RST# is low, DEVSEL#, TRDY# and STOP# are high and the block is idle. Reset clears the command word and loads every base bit with 1.
- R9: The I/O window spans 2^IO_LOG2 bytes, clamped to at most 256.
- R10: A memory burst transfers one phase per clock while IRDY# and TRDY# are low, with lcl_addr increasing by 4 per completed phase; a phase with IRDY# high transfers nothing.
- R11: A data phase completing with FRAME# high is followed by one cycle with DEVSEL#, TRDY# and STOP# all high, then idle.
- R12: A config data phase drives STOP# low with TRDY#. If it completes while FRAME# is still low, the next cycles hold TRDY# high and STOP#/DEVSEL# low until FRAME# rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| frame_n | input | 1 | FRAME# from the master |
| irdy_n | input | 1 | IRDY# from the master |
| cbe_n | input | 4 | Command in address phase, byte enables (active low) in data phases |
| ad_in | input | 32 | Address/data bus as received |
| idsel | input | 1 | Configuration select |
| ad_out | output | 32 | Read data to drive onto the bus |
| ad_oe | output | 1 | High when ad_out should be driven |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| lcl_wr | output | 1 | Local write strobe, one per completed write phase |
| lcl_rd | output | 1 | Local read strobe, one per completed read phase |
| lcl_io | output | 1 | 1 for I/O space, 0 for memory space |
| lcl_addr | output | 32 | Current data-phase byte address |
| lcl_wdata | output | 32 | Write data |
| lcl_be | output | 4 | Byte enables, active high; all ones on reads |
| lcl_rdata | input | 32 | Read data from the user logic, used in the same cycle |

## Verification
DEVSEL# and TRDY# come from the state register. They change two edges after the address-phase edge and are sampled at the falling edge after that second rising edge. The bench also samples at the falling edge one clock earlier to confirm that nothing showed up too soon. Local strobes, byte enables and read data are combinational from the state and the current bus inputs, so they are sampled one time unit after the inputs change within the same clock. The turnaround and idle states are checked at the next two falling edges. Every command code is swept against a memory-window, an I/O-window and a configuration address, with the expected claim worked out from the command word and base values the bench tracks itself.

// File: rtl/pci_tgt_responder.sv
module pci_tgt_responder #(
  parameter logic [31:0] ID_WORD    = 32'hC0DE_1A2B,
  parameter logic [31:0] CLASS_WORD = 32'h0580_0001,
  parameter int          MEM_LOG2   = 12,
  parameter int          IO_LOG2_REQ = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  input  logic        idsel,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        lcl_wr,
  output logic        lcl_rd,
  output logic        lcl_io,
  output logic [31:0] lcl_addr,
  output logic [31:0] lcl_wdata,
  output logic [3:0]  lcl_be,
  input  logic [31:0] lcl_rdata
);
  localparam int IO_LOG2 = (IO_LOG2_REQ > 8) ? 8 : ((IO_LOG2_REQ < 2) ? 2 : IO_LOG2_REQ);
  localparam logic [15:0] CMD_WMASK = 16'h0147;
  localparam logic [15:0] STAT_WORD = 16'h0200;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_DATA, S_HOLD, S_TURN} st_t;

  st_t                  st;
  logic                 frame_q;
  logic [3:0]           cmd_q;
  logic [31:0]          addr_q;
  logic                 idsel_q;
  logic                 is_cfg_q;
  logic                 is_io_q;
  logic [15:0]          cmd_reg;
  logic [31-MEM_LOG2:0] mem_base;
  logic [31-IO_LOG2:0]  io_base;
  logic [31:0]          cfg_rd;

  function automatic logic [31:0] merge_be(input logic [31:0] old_w, input logic [31:0] new_w,
                                           input logic [3:0] en);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = en[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction

  wire addr_phase = (st == S_IDLE) && !frame_n && frame_q;
  wire is_wr      = cmd_q[0];
  wire mem_cmd    = (cmd_q == 4'b0110) || (cmd_q == 4'b0111) || (cmd_q == 4'b1100) ||
                    (cmd_q == 4'b1110) || (cmd_q == 4'b1111);
  wire io_cmd     = (cmd_q[3:1] == 3'b001);
  wire cfg_cmd    = (cmd_q[3:1] == 3'b101);
  wire mem_hit    = mem_cmd && cmd_reg[1] && (addr_q[31:MEM_LOG2] == mem_base);
  wire io_hit     = io_cmd && cmd_reg[0] && (addr_q[31:IO_LOG2] == io_base);
  wire cfg_hit    = cfg_cmd && idsel_q && (addr_q[1:0] == 2'b00);
  wire xfer       = (st == S_DATA) && !irdy_n;
  wire cfg_wr     = xfer && is_cfg_q && is_wr;
  wire [31:0] wr_word = merge_be(cfg_rd, ad_in, ~cbe_n);

  always_comb begin
    case (addr_q[7:2])
      6'd0:    cfg_rd = ID_WORD;
      6'd1:    cfg_rd = {STAT_WORD, cmd_reg};
      6'd2:    cfg_rd = CLASS_WORD;
      6'd4:    cfg_rd = {mem_base, {MEM_LOG2{1'b0}}};
      6'd5:    cfg_rd = {io_base, {(IO_LOG2-1){1'b0}}, 1'b1};
      default: cfg_rd = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      frame_q  <= 1'b1;
      cmd_q    <= 4'h0;
      addr_q   <= 32'h0;
      idsel_q  <= 1'b0;
      is_cfg_q <= 1'b0;
      is_io_q  <= 1'b0;
      cmd_reg  <= 16'h0;
      mem_base <= '1;
      io_base  <= '1;
    end else begin
      frame_q <= frame_n;
      case (st)
        S_IDLE: if (addr_phase) begin
          cmd_q   <= cbe_n;
          addr_q  <= ad_in;
          idsel_q <= idsel;
          st      <= S_DEC;
        end
        S_DEC: begin
          is_cfg_q <= cfg_hit;
          is_io_q  <= io_hit;
          st       <= (mem_hit || io_hit || cfg_hit) ? S_DATA : S_IDLE;
        end
        S_DATA: if (!irdy_n) begin
          addr_q <= addr_q + 32'd4;
          if (frame_n)       st <= S_TURN;
          else if (is_cfg_q) st <= S_HOLD;
        end
        S_HOLD: if (frame_n) st <= S_TURN;
        default: st <= S_IDLE;
      endcase
      if (cfg_wr) begin
        case (addr_q[7:2])
          6'd1:    cmd_reg  <= wr_word[15:0] & CMD_WMASK;
          6'd4:    mem_base <= wr_word[31:MEM_LOG2];
          6'd5:    io_base  <= wr_word[31:IO_LOG2];
          default: ;
        endcase
      end
    end
  end

  assign devsel_n  = !((st == S_DATA) || (st == S_HOLD));
  assign trdy_n    = !(st == S_DATA);
  assign stop_n    = !(((st == S_DATA) || (st == S_HOLD)) && is_cfg_q);
  assign ad_oe     = (st == S_DATA) && !is_wr;
  assign ad_out    = is_cfg_q ? cfg_rd : lcl_rdata;
  assign lcl_wr    = xfer && is_wr && !is_cfg_q;
  assign lcl_rd    = xfer && !is_wr && !is_cfg_q;
  assign lcl_io    = is_io_q;
  assign lcl_addr  = addr_q;
  assign lcl_wdata = ad_in;
  assign lcl_be    = is_wr ? ~cbe_n : 4'hF;
endmodule

// File: rtl/pci_tgt_responder_chk.sv
module pci_tgt_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       stop_n,
  input logic       lcl_wr,
  input logic       lcl_rd,
  input logic [3:0] lcl_be,
  input logic       ad_oe,
  input logic       ad7,
  input logic [3:0] cmd_q,
  input logic [7:0] addr_lo,
  input logic       is_cfg_q
);
  // R1
  devsel_medium_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n, 2));
  // R1
  trdy_with_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
  // R2
  cfg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(devsel_n) && cmd_q[3:1] == 3'b101) |-> addr_lo[1:0] == 2'b00);
  // R4
  wr_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_wr |-> (!trdy_n && !irdy_n));
  // R5
  rd_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_rd |-> lcl_be == 4'hF);
  // R6
  no_intack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> cmd_q != 4'h0);
  // R7
  step_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && is_cfg_q && addr_lo[7:2] == 6'd1) |-> !ad7);
  // R8
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (devsel_n && trdy_n && stop_n));
  // R10
  burst_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !frame_n && stop_n) |=> !trdy_n);
  // R11
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n));
  // R12
  disconnect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && !frame_n && !stop_n) |=> (trdy_n && !stop_n && !devsel_n));
endmodule

bind pci_tgt_responder pci_tgt_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
  .lcl_wr(lcl_wr), .lcl_rd(lcl_rd), .lcl_be(lcl_be), .ad_oe(ad_oe),
  .ad7(ad_out[7]), .cmd_q(cmd_q), .addr_lo(addr_q[7:0]), .is_cfg_q(is_cfg_q)
);

// File: tb/tb_pci_tgt_responder.sv
module tb_pci_tgt_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = 32'h0;
  logic [31:0] ad_out, lcl_addr, lcl_wdata, lcl_rdata;
  logic        ad_oe, devsel_n, trdy_n, stop_n, lcl_wr, lcl_rd, lcl_io;
  logic [3:0]  lcl_be;

  int n_chk = 0, n_bad = 0;
  logic [15:0] creg;
  logic [31:0] mbar, iobar, rd;

  localparam logic [31:0] ID_W = 32'hC0DE_1A2B;
  localparam logic [31:0] CLS_W = 32'h0580_0001;

  always #2 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  assign lcl_rdata = model(lcl_addr);

  pci_tgt_responder dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_in(ad_in), .idsel(idsel), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .lcl_wr(lcl_wr),
    .lcl_rd(lcl_rd), .lcl_io(lcl_io), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
    .lcl_be(lcl_be), .lcl_rdata(lcl_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit claim_model(input logic [3:0] c, input logic [31:0] a, input bit sel);
    bit m, io, cf;
    m  = (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
    io = (c == 4'h2) || (c == 4'h3);
    cf = (c == 4'hA) || (c == 4'hB);
    return (m && creg[1] && a[31:12] == mbar[31:12]) ||
           (io && creg[0] && a[31:8] == iobar[31:8]) ||
           (cf && sel && a[1:0] == 2'b00);
  endfunction

  task automatic txn(input logic [3:0] c, input logic [31:0] a, input bit sel,
                     input logic [31:0] d, input logic [3:0] ben, input string req,
                     output logic [31:0] rdv);
    bit cl, cf, w, io;
    cl = claim_model(c, a, sel);
    cf = (c[3:1] == 3'b101);
    io = (c[3:1] == 3'b001);
    w  = c[0];
    @(negedge clk);
    frame_n = 1'b0; cbe_n = c; ad_in = a; idsel = sel; irdy_n = 1'b1;
    @(negedge clk);
    chk(devsel_n === 1'b1, "R1 early", 32'(devsel_n), 32'd1);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = ben; ad_in = d; idsel = 1'b0;
    @(negedge clk);
    #1;
    rdv = ad_out;
    chk(devsel_n === !cl, req, 32'(devsel_n), 32'(!cl));
    if (cl) begin
      chk(trdy_n === 1'b0, "R1 trdy", 32'(trdy_n), 32'd0);
      if (cf) chk(!lcl_wr && !lcl_rd, "R2 no local", {lcl_wr, lcl_rd}, 32'd0);
      else if (w) begin
        chk(lcl_wr === 1'b1, "R4 strobe", 32'(lcl_wr), 32'd1);
        chk(lcl_wdata === d && lcl_be === ~ben && lcl_addr === a && lcl_io === io,
            "R4 fields", {lcl_be, lcl_wdata[27:0]}, {~ben, d[27:0]});
      end else begin
        chk(lcl_rd === 1'b1 && ad_oe === 1'b1, "R5 strobe", {lcl_rd, ad_oe}, 32'd3);
        chk(lcl_be === 4'hF, "R5 be", 32'(lcl_be), 32'hF);
        chk(ad_out === model(a), "R5 data", ad_out, model(a));
      end
    end else
      chk(!lcl_wr && !lcl_rd, "R3 unclaimed quiet", {lcl_wr, lcl_rd}, 32'd0);
    @(negedge clk);
    if (cl) chk(devsel_n && trdy_n && stop_n, "R11 turn", {devsel_n, trdy_n, stop_n}, 32'd7);
    irdy_n = 1'b1;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n, "R11 idle", {devsel_n, trdy_n, stop_n}, 32'd7);
  endtask

  task automatic cfg_w(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] ben);
    logic [31:0] dummy;
    txn(4'hB, {24'h0, idx, 2'b00}, 1'b1, d, ben, "R2 cfg write", dummy);
  endtask

  task automatic cfg_r(input logic [5:0] idx, input logic [31:0] exp, input string req);
    logic [31:0] v;
    txn(4'hA, {24'h0, idx, 2'b00}, 1'b1, 32'h0, 4'hA, "R2 cfg read", v);
    chk(v === exp, req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    creg = 16'h0; mbar = 32'hFFFF_F000; iobar = 32'hFFFF_FF01;
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n, "R8 reset outs", {devsel_n, trdy_n, stop_n}, 32'd7);
    rst_n = 1'b1;
    cfg_r(6'd0, ID_W, "R7 id");
    cfg_r(6'd1, 32'h0200_0000, "R8 cmd cleared");
    cfg_r(6'd4, 32'hFFFF_F000, "R8 mem bar mask");
    cfg_r(6'd5, 32'hFFFF_FF01, "R8 io bar mask");
    txn(4'h6, 32'hFFFF_F010, 1'b0, 0, 4'h0, "R3 disabled mem", rd);

    cfg_w(6'd1, 32'hFFFF_FFFF, 4'h0); creg = 16'h0147;
    cfg_r(6'd1, 32'h0200_0147, "R7 bit7 zero");
    cfg_w(6'd1, 32'h0000_0003, 4'hE); creg = 16'h0103;
    cfg_r(6'd1, 32'h0200_0103, "R7 byte enable cmd");
    cfg_w(6'd4, 32'h1234_5678, 4'h7);
    cfg_r(6'd4, 32'h12FF_F000, "R7 bar byte");
    cfg_w(6'd4, 32'h4000_0ABC, 4'h0); mbar = 32'h4000_0000;
    cfg_r(6'd4, 32'h4000_0000, "R7 mem bar");
    cfg_w(6'd5, 32'h0000_12FF, 4'h0); iobar = 32'h0000_1201;
    cfg_r(6'd5, 32'h0000_1201, "R7 io bar");

    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 3; s++) begin
        logic [31:0] a;
        string rq;
        a  = (s == 0) ? 32'h4000_0010 : (s == 1) ? 32'h0000_1210 : 32'h0000_0008;
        rq = (c == 0) ? "R6 intack" : (s == 2) ? "R2 cfg claim" : "R3 claim";
        txn(4'(c), a, s == 2, {4'(c), 4'(s), 24'h5A3C96}, 4'(c) ^ 4'h5, rq, rd);
        if (s == 2 && c == 4'hA)
          chk(rd === CLS_W, "R7 class", rd, CLS_W);
      end
    end

    txn(4'h2, 32'h0000_12FC, 1'b0, 0, 4'h0, "R9 io top", rd);
    txn(4'h2, 32'h0000_1300, 1'b0, 0, 4'h0, "R9 io above", rd);
    txn(4'h3, 32'h0000_11FC, 1'b0, 32'h1, 4'h0, "R9 io below", rd);
    txn(4'h6, 32'h4000_0FFC, 1'b0, 0, 4'h0, "R3 mem top", rd);
    txn(4'h7, 32'h4000_1000, 1'b0, 32'h2, 4'h0, "R3 mem above", rd);
    txn(4'hA, 32'h0000_0000, 1'b0, 0, 4'h0, "R2 no idsel", rd);
    txn(4'hA, 32'h0000_0001, 1'b1, 0, 4'h0, "R2 misaligned", rd);

    begin
      int k = 0;
      bit waited = 0;
      logic [31:0] base = 32'h4000_0100;
      @(negedge clk);
      frame_n = 1'b0; cbe_n = 4'h7; ad_in = base; irdy_n = 1'b1;
      @(negedge clk);
      irdy_n = 1'b0; ad_in = 32'hD000_0000; cbe_n = 4'h0;
      while (k < 4) begin
        @(negedge clk);
        if (k == 2 && !waited) begin
          waited = 1;
          irdy_n = 1'b1;
          #1;
          chk(!lcl_wr && !trdy_n, "R10 wait", {lcl_wr, trdy_n}, 32'd0);
          continue;
        end
        irdy_n = 1'b0; ad_in = 32'hD000_0000 + 32'(k); cbe_n = 4'(k); frame_n = (k == 3);
        #1;
        chk(lcl_wr && lcl_addr === base + 32'(4*k) && lcl_wdata === 32'hD000_0000 + 32'(k)
            && lcl_be === ~4'(k), "R10 burst write", lcl_addr, base + 32'(4*k));
        k++;
      end
      @(negedge clk);
      chk(devsel_n && trdy_n && stop_n, "R11 burst end", {devsel_n, trdy_n, stop_n}, 32'd7);
      irdy_n = 1'b1;
    end

    begin
      logic [31:0] base = 32'h4000_0200;
      @(negedge clk);
      frame_n = 1'b0; cbe_n = 4'hC; ad_in = base; irdy_n = 1'b1;
      @(negedge clk);
      irdy_n = 1'b0; cbe_n = 4'h3;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        frame_n = (k == 2);
        #1;
        chk(lcl_rd && lcl_be === 4'hF && ad_out === model(base + 32'(4*k)),
            "R10 burst read", ad_out, model(base + 32'(4*k)));
      end
      @(negedge clk);
      irdy_n = 1'b1;
    end

    @(negedge clk);
    frame_n = 1'b0; cbe_n = 4'hA; ad_in = 32'h0; idsel = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    idsel = 1'b0; irdy_n = 1'b0;
    @(negedge clk);
    chk(!trdy_n && !stop_n && ad_out === ID_W, "R12 disconnect data", ad_out, ID_W);
    @(negedge clk);
    chk(trdy_n && !stop_n && !devsel_n, "R12 hold", {devsel_n, trdy_n, stop_n}, 32'd2);
    frame_n = 1'b1;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n, "R11 after disconnect", {devsel_n, trdy_n, stop_n}, 32'd7);
    irdy_n = 1'b1;

    cfg_w(6'd1, 32'h0000_0001, 4'hE); creg = 16'h0101;
    txn(4'h6, 32'h4000_0010, 1'b0, 0, 4'h0, "R3 mem bit off", rd);
    txn(4'h2, 32'h0000_1210, 1'b0, 0, 4'h0, "R3 io still on", rd);

    @(negedge clk);
    frame_n = 1'b0; cbe_n = 4'h2; ad_in = 32'h0000_1220; irdy_n = 1'b1;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(devsel_n && trdy_n && stop_n, "R8 mid reset", {devsel_n, trdy_n, stop_n}, 32'd7);
    @(negedge clk);
    rst_n = 1'b1;
    creg = 16'h0; mbar = 32'hFFFF_F000; iobar = 32'hFFFF_FF01;
    cfg_r(6'd1, 32'h0200_0000, "R8 cmd after reset");
    cfg_r(6'd4, 32'hFFFF_F000, "R8 mem bar after reset");
    cfg_r(6'd5, 32'hFFFF_FF01, "R8 io bar after reset");
    txn(4'h2, 32'h0000_1210, 1'b0, 0, 4'h0, "R8 io off after reset", rd);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule